// File: doc/BRIEF.md
# Breakpoint Status and Trigger Unit

This unit sits behind the instruction and data breakpoint comparators of a processor debug block. Each cycle it receives the raw match vectors from those comparators, together with the qualifiers that decide whether a match may count. For instructions the qualifiers are whether the instruction retired or took an exception. For data they are the completion strobe, the access direction, the value-compare mode, data validity and the priority of any exception on the access. From these it keeps one sticky status bit per channel and two sticky flags for imprecise load and store matches. It also decides whether a debug exception must be requested.

A channel can be configured as a triggerpoint. A triggerpoint is qualified in the same way as a breakpoint, but it only records status. Data accesses may complete out of order. Each completion is evaluated when it arrives, and only the first qualifying match outside debug mode raises a request. Later matches, and matches that arrive while the core is already in debug mode, only update status. Software clears status through a write-one-to-clear port. A hardware set wins over a clear of the same bit in the same cycle.

Top module: `brk_status_unit`

## Requirements
- R1: A match on a channel whose trigger-enable bit is 1 sets that channel's status bit and never causes a debug request.
- R2: A qualified match sets its channel status bit on the clock edge that ends the match cycle, so the bit reads 1 one cycle later. The rule is the same for breakpoints and triggerpoints.
- R3: Status bits and imprecise flags are sticky. A `sw_wr_i` write clears each bit whose data bit is 1 and leaves bits written 0 unchanged. A set and a clear of the same bit in one cycle leave it set. With `sw_sel_i`=0, data bits [NUM_IBRK-1:0] address the instruction status bits. With `sw_sel_i`=1, bits [NUM_DBRK-1:0] address the data status bits, bit NUM_DBRK addresses the imprecise-load flag and bit NUM_DBRK+1 addresses the imprecise-store flag.
- R4: An instruction match counts only in a cycle where `ib_retire_i` or `ib_exc_i` is 1.
- R5: A data match counts only with `db_done_i`=1 and `db_exc_prio_i` <= DBRK_PRIO (default 3). A code of 0 means the access raised no exception, and a larger code means a higher priority.
- R6: On a channel with `db_valcmp_i`=1, a load match counts only with `db_data_ok_i`=1, while a store match counts regardless of data validity.
- R7: Every counted data match on a completion with `db_imprecise_i`=1 sets the imprecise-load flag (`db_store_i`=0) or the imprecise-store flag (`db_store_i`=1). This applies to the first such match and to every later one.
- R8: A counted match on a channel with trigger-enable 0 raises `dbg_req_o` for exactly one cycle, one cycle after the match. `dbg_mode_o` becomes 1 the cycle after the pulse and returns to 0 one cycle after `dbg_ret_i`.
- R9: No request is raised while `dbg_mode_o` or `dbg_req_o` is 1. Status bits and flags are still set in that case.
- R10: When several requesting matches occur in the same cycle, an instruction channel wins over a data channel, and the lowest index wins within a kind. During the pulse, `dbg_req_data_o` gives the kind (1 = data), `dbg_req_chan_o` gives the index, and `dbg_req_imp_o` is 1 only for a data request on an imprecise completion.
- R11: Reset clears all status bits, both flags, the request and debug mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ib_match_i | input | NUM_IBRK | Instruction comparator matches |
| ib_trig_en_i | input | NUM_IBRK | Instruction channel is a triggerpoint |
| ib_retire_i | input | 1 | Matched instruction fully executed |
| ib_exc_i | input | 1 | Exception taken on the matched instruction |
| db_done_i | input | 1 | A data access completes this cycle |
| db_match_i | input | NUM_DBRK | Data comparator matches for the completing access |
| db_trig_en_i | input | NUM_DBRK | Data channel is a triggerpoint |
| db_valcmp_i | input | NUM_DBRK | Data channel uses value compare |
| db_store_i | input | 1 | Completing access is a store |
| db_imprecise_i | input | 1 | Completion is out of order (imprecise) |
| db_data_ok_i | input | 1 | Access data is valid |
| db_exc_prio_i | input | 3 | Priority code of exception on the access, 0 = none |
| dbg_ret_i | input | 1 | Return from debug mode |
| sw_wr_i | input | 1 | Software write-one-to-clear strobe |
| sw_sel_i | input | 1 | Write target: 0 instruction word, 1 data word |
| sw_wdata_i | input | SW_W | Clear mask |
| ib_status_o | output | NUM_IBRK | Sticky instruction channel status |
| db_status_o | output | NUM_DBRK | Sticky data channel status |
| imp_load_o | output | 1 | Sticky imprecise-load flag |
| imp_store_o | output | 1 | Sticky imprecise-store flag |
| dbg_req_o | output | 1 | One-cycle debug exception request |
| dbg_req_imp_o | output | 1 | Request is imprecise |
| dbg_req_data_o | output | 1 | Request comes from a data channel |
| dbg_req_chan_o | output | CHAN_W | Channel index of the request |
| dbg_mode_o | output | 1 | Debug mode state |

## Verification
The status bits, both flags, the request pulse and its kind, index and precision fields are all due one clock after the cycle that presents a match. Debug mode follows one clock after the pulse, and a return input takes effect one clock after it is seen. The bench changes inputs on the falling edge and lets one rising edge pass. At the next falling edge it compares every output against a bench model that was advanced by exactly one step with the same inputs. Directed cases check the corner values literally at that same sample point.

// File: rtl/brk_status_pkg.sv
package brk_status_pkg;

  localparam int EXC_PRIO_W = 3;
  typedef logic [EXC_PRIO_W-1:0] exc_prio_t;

  // Decide whether one data channel's comparator hit is allowed to count.
  function automatic logic data_hit_ok(
    input logic      hit,
    input logic      valcmp,
    input logic      data_ok,
    input logic      is_store,
    input exc_prio_t prio,
    input exc_prio_t limit
  );
    return hit && (prio <= limit) && (!valcmp || is_store || data_ok);
  endfunction

endpackage

// File: rtl/brk_sticky_bank.sv
module brk_sticky_bank #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_i) | set_i;
  end

  // R3: a set bit only falls when software asked for it
  p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~q_o & $past(q_o) & ~$past(clr_i)) == '0));

  // R3: set request beats a same-cycle clear
  p_set_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~q_o & $past(set_i)) == '0));

endmodule

// File: rtl/brk_req_ctrl.sv
module brk_req_ctrl #(
  parameter int NI = 4,
  parameter int ND = 2,
  parameter int CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NI-1:0] ib_cand_i,
  input  logic [ND-1:0] db_cand_i,
  input  logic          db_imprecise_i,
  input  logic          dbg_ret_i,
  output logic          req_o,
  output logic          req_imp_o,
  output logic          req_data_o,
  output logic [CW-1:0] req_chan_o,
  output logic          mode_o
);

  function automatic logic [CW-1:0] first_ib(input logic [NI-1:0] v);
    logic [CW-1:0] idx;
    idx = '0;
    for (int i = NI - 1; i >= 0; i--) if (v[i]) idx = CW'(i);
    return idx;
  endfunction

  function automatic logic [CW-1:0] first_db(input logic [ND-1:0] v);
    logic [CW-1:0] idx;
    idx = '0;
    for (int i = ND - 1; i >= 0; i--) if (v[i]) idx = CW'(i);
    return idx;
  endfunction

  logic any_ib_w, any_db_w, blocked_w, fire_w;
  assign any_ib_w  = |ib_cand_i;
  assign any_db_w  = |db_cand_i;
  assign blocked_w = mode_o | req_o;
  assign fire_w    = !blocked_w && (any_ib_w || any_db_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o      <= 1'b0;
      req_imp_o  <= 1'b0;
      req_data_o <= 1'b0;
      req_chan_o <= '0;
      mode_o     <= 1'b0;
    end else begin
      req_o <= fire_w;
      if (fire_w) begin
        req_data_o <= !any_ib_w;
        req_imp_o  <= !any_ib_w && db_imprecise_i;
        req_chan_o <= any_ib_w ? first_ib(ib_cand_i) : first_db(db_cand_i);
      end
      if (req_o)          mode_o <= 1'b1;
      else if (dbg_ret_i) mode_o <= 1'b0;
    end
  end

  // R8: the request lasts one cycle and is followed by debug mode
  p_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> (!req_o && mode_o));

  // R9: nothing is requested while already in debug mode
  p_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o |=> !req_o);

  // R10: instruction candidates take the request over data ones
  p_instr_first_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_ib_w && !blocked_w) |=> (req_o && !req_data_o && !req_imp_o));

endmodule

// File: rtl/brk_status_unit.sv
module brk_status_unit
  import brk_status_pkg::*;
#(
  parameter int NUM_IBRK  = 4,
  parameter int NUM_DBRK  = 2,
  parameter int DBRK_PRIO = 3,
  localparam int SW_W     = (NUM_IBRK > NUM_DBRK + 2) ? NUM_IBRK : NUM_DBRK + 2,
  localparam int MAX_CH   = (NUM_IBRK > NUM_DBRK) ? NUM_IBRK : NUM_DBRK,
  localparam int CHAN_W   = $clog2(MAX_CH < 2 ? 2 : MAX_CH)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_IBRK-1:0]   ib_match_i,
  input  logic [NUM_IBRK-1:0]   ib_trig_en_i,
  input  logic                  ib_retire_i,
  input  logic                  ib_exc_i,
  input  logic                  db_done_i,
  input  logic [NUM_DBRK-1:0]   db_match_i,
  input  logic [NUM_DBRK-1:0]   db_trig_en_i,
  input  logic [NUM_DBRK-1:0]   db_valcmp_i,
  input  logic                  db_store_i,
  input  logic                  db_imprecise_i,
  input  logic                  db_data_ok_i,
  input  logic [EXC_PRIO_W-1:0] db_exc_prio_i,
  input  logic                  dbg_ret_i,
  input  logic                  sw_wr_i,
  input  logic                  sw_sel_i,
  input  logic [SW_W-1:0]       sw_wdata_i,
  output logic [NUM_IBRK-1:0]   ib_status_o,
  output logic [NUM_DBRK-1:0]   db_status_o,
  output logic                  imp_load_o,
  output logic                  imp_store_o,
  output logic                  dbg_req_o,
  output logic                  dbg_req_imp_o,
  output logic                  dbg_req_data_o,
  output logic [CHAN_W-1:0]     dbg_req_chan_o,
  output logic                  dbg_mode_o
);

  localparam exc_prio_t PRIO_LIMIT = exc_prio_t'(DBRK_PRIO);
  localparam int        DW         = NUM_DBRK + 2;

  // Qualified matches (named events for the checks)
  logic [NUM_IBRK-1:0] ib_qual_w, ib_cand_w, ib_clr_w;
  logic [NUM_DBRK-1:0] db_qual_w, db_cand_w;
  logic [DW-1:0]       db_set_w, db_clr_w, db_q_w;
  logic                imp_load_set_w, imp_store_set_w, ib_commit_w;

  assign ib_commit_w = ib_retire_i | ib_exc_i;
  assign ib_qual_w   = ib_match_i & {NUM_IBRK{ib_commit_w}};
  assign ib_cand_w   = ib_qual_w & ~ib_trig_en_i;

  for (genvar g = 0; g < NUM_DBRK; g++) begin : g_dchan
    assign db_qual_w[g] = db_done_i &&
      data_hit_ok(db_match_i[g], db_valcmp_i[g], db_data_ok_i, db_store_i,
                  db_exc_prio_i, PRIO_LIMIT);
  end
  assign db_cand_w = db_qual_w & ~db_trig_en_i;

  assign imp_load_set_w  = db_imprecise_i && !db_store_i && (|db_qual_w);
  assign imp_store_set_w = db_imprecise_i &&  db_store_i && (|db_qual_w);

  // Software write-one-to-clear decode
  assign ib_clr_w = (sw_wr_i && !sw_sel_i) ? sw_wdata_i[NUM_IBRK-1:0] : '0;
  assign db_clr_w = (sw_wr_i &&  sw_sel_i) ? sw_wdata_i[DW-1:0]       : '0;
  assign db_set_w = {imp_store_set_w, imp_load_set_w, db_qual_w};

  brk_sticky_bank #(.W(NUM_IBRK)) u_ib_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ib_qual_w),
    .clr_i  (ib_clr_w),
    .q_o    (ib_status_o)
  );

  brk_sticky_bank #(.W(DW)) u_db_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (db_set_w),
    .clr_i  (db_clr_w),
    .q_o    (db_q_w)
  );

  assign db_status_o = db_q_w[NUM_DBRK-1:0];
  assign imp_load_o  = db_q_w[NUM_DBRK];
  assign imp_store_o = db_q_w[NUM_DBRK+1];

  brk_req_ctrl #(.NI(NUM_IBRK), .ND(NUM_DBRK), .CW(CHAN_W)) u_req (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ib_cand_i      (ib_cand_w),
    .db_cand_i      (db_cand_w),
    .db_imprecise_i (db_imprecise_i),
    .dbg_ret_i      (dbg_ret_i),
    .req_o          (dbg_req_o),
    .req_imp_o      (dbg_req_imp_o),
    .req_data_o     (dbg_req_data_o),
    .req_chan_o     (dbg_req_chan_o),
    .mode_o         (dbg_mode_o)
  );

  // R1: with no non-trigger candidate there is no request next cycle
  p_trig_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|ib_cand_w) && !(|db_cand_w)) |=> !dbg_req_o);

  // R2: every qualified instruction match is visible one cycle later
  p_status_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ib_status_o & $past(ib_qual_w)) == $past(ib_qual_w)));

  // R4: no instruction status bit rises without retire or exception
  p_instr_commit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ib_commit_w |=> ((ib_status_o & ~$past(ib_status_o)) == '0));

  // R5: a higher-priority exception keeps data status bits from rising
  p_prio_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_exc_prio_i > PRIO_LIMIT) |=> ((db_status_o & ~$past(db_status_o)) == '0));

  // R7: a precise completion never raises an imprecise flag
  p_imp_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !db_imprecise_i |=> (!$rose(imp_load_o) && !$rose(imp_store_o)));

endmodule

// File: tb/brk_status_unit_tb_top.sv
module brk_status_unit_tb_top;

  localparam int NI = 4;
  localparam int ND = 2;
  localparam int LIM = 3;
  localparam int SWW = 4;
  localparam int CLK_NS = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  logic [NI-1:0] ib_match, ib_trig;
  logic ib_retire, ib_exc;
  logic db_done, db_store, db_imp, db_ok;
  logic [ND-1:0] db_match, db_trig, db_valcmp;
  logic [2:0] db_prio;
  logic dbg_ret, sw_wr, sw_sel;
  logic [SWW-1:0] sw_wdata;

  logic [NI-1:0] ib_status;
  logic [ND-1:0] db_status;
  logic imp_load, imp_store, req, req_imp, req_data, mode;
  logic [1:0] req_chan;

  brk_status_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ib_match_i(ib_match), .ib_trig_en_i(ib_trig),
    .ib_retire_i(ib_retire), .ib_exc_i(ib_exc),
    .db_done_i(db_done), .db_match_i(db_match), .db_trig_en_i(db_trig),
    .db_valcmp_i(db_valcmp), .db_store_i(db_store), .db_imprecise_i(db_imp),
    .db_data_ok_i(db_ok), .db_exc_prio_i(db_prio), .dbg_ret_i(dbg_ret),
    .sw_wr_i(sw_wr), .sw_sel_i(sw_sel), .sw_wdata_i(sw_wdata),
    .ib_status_o(ib_status), .db_status_o(db_status),
    .imp_load_o(imp_load), .imp_store_o(imp_store),
    .dbg_req_o(req), .dbg_req_imp_o(req_imp), .dbg_req_data_o(req_data),
    .dbg_req_chan_o(req_chan), .dbg_mode_o(mode)
  );

  int checks = 0;
  int fails = 0;

  // Bench model state
  logic [NI-1:0] m_ib;
  logic [ND-1:0] m_db;
  logic m_il, m_is, m_req, m_imp, m_data, m_mode;
  int m_chan;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit d_hit(input int c);
    if (!db_done || !db_match[c]) return 1'b0;
    if (int'(db_prio) > LIM) return 1'b0;
    if (db_valcmp[c] && !db_store && !db_ok) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int lowest(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic model_reset();
    m_ib = '0; m_db = '0; m_il = 0; m_is = 0;
    m_req = 0; m_imp = 0; m_data = 0; m_mode = 0; m_chan = 0;
  endtask

  task automatic model_advance();
    logic [NI-1:0] iq, icand;
    logic [ND-1:0] dq, dcand;
    logic [SWW-1:0] ci, cd;
    logic n_req;
    iq = (ib_retire || ib_exc) ? ib_match : '0;
    for (int c = 0; c < ND; c++) dq[c] = d_hit(c);
    icand = iq & ~ib_trig;
    dcand = dq & ~db_trig;
    ci = (sw_wr && !sw_sel) ? sw_wdata : '0;
    cd = (sw_wr && sw_sel) ? sw_wdata : '0;
    n_req = !(m_mode || m_req) && ((icand != 0) || (dcand != 0));
    m_mode = m_req ? 1'b1 : (dbg_ret ? 1'b0 : m_mode);
    if (n_req) begin
      if (icand != 0) begin m_data = 0; m_imp = 0; m_chan = lowest(32'(icand)); end
      else begin m_data = 1; m_imp = db_imp; m_chan = lowest(32'(dcand)); end
    end
    m_req = n_req;
    m_ib = (m_ib & ~ci) | iq;
    m_db = (m_db & ~cd[ND-1:0]) | dq;
    m_il = (m_il & !cd[ND]) | (db_imp && !db_store && (dq != 0));
    m_is = (m_is & !cd[ND+1]) | (db_imp && db_store && (dq != 0));
  endtask

  task automatic compare_all();
    chk("R2 R4 instruction status", 32'(ib_status), 32'(m_ib));
    chk("R5 R6 data status", 32'(db_status), 32'(m_db));
    chk("R7 imprecise load flag", 32'(imp_load), 32'(m_il));
    chk("R7 imprecise store flag", 32'(imp_store), 32'(m_is));
    chk("R8 request pulse", 32'(req), 32'(m_req));
    chk("R9 debug mode", 32'(mode), 32'(m_mode));
    if (m_req) begin
      chk("R10 request kind", 32'(req_data), 32'(m_data));
      chk("R10 request channel", 32'(req_chan), 32'(m_chan));
      chk("R10 request precision", 32'(req_imp), 32'(m_imp));
    end
  endtask

  task automatic idle_inputs();
    ib_match = '0; ib_retire = 0; ib_exc = 0;
    db_done = 0; db_match = '0; db_valcmp = '0; db_store = 0; db_imp = 0;
    db_ok = 0; db_prio = '0; dbg_ret = 0; sw_wr = 0; sw_sel = 0; sw_wdata = '0;
  endtask

  // Inputs are set at a falling edge; one rising edge passes; check at next falling edge.
  task automatic step();
    model_advance();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    idle_inputs();
    ib_trig = '0; db_trig = '0;
    model_reset();
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset instruction status", 32'(ib_status), 0);
    chk("R11 reset data status", 32'(db_status), 0);
    chk("R11 reset request and mode", 32'({req, mode, imp_load, imp_store}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: triggerpoint records status, no request
    ib_trig = '1; ib_match = 4'b0100; ib_retire = 1;
    step();
    chk("R1 trigger status", 32'(ib_status), 32'h4);
    chk("R1 trigger no request", 32'(req), 0);
    idle_inputs();
    step();
    chk("R1 trigger no request later", 32'(req), 0);

    // R3: writing 0 has no effect, set wins, writing 1 clears
    sw_wr = 1; sw_sel = 0; sw_wdata = 4'b1011;
    step();
    chk("R3 zero write keeps bit", 32'(ib_status), 32'h4);
    sw_wdata = 4'b0100; ib_match = 4'b0100; ib_retire = 1;
    step();
    chk("R3 set wins over clear", 32'(ib_status), 32'h4);
    idle_inputs(); sw_wr = 1; sw_wdata = 4'b0100;
    step();
    chk("R3 one write clears", 32'(ib_status), 0);

    // R4: match without retire or exception is ignored
    idle_inputs(); ib_match = 4'b0001;
    step();
    chk("R4 uncommitted match ignored", 32'(ib_status), 0);
    ib_exc = 1;
    step();
    chk("R4 exception commits match", 32'(ib_status), 32'h1);

    // R5: priority above limit blocks, equal to limit counts
    idle_inputs(); db_trig = '1; db_done = 1; db_match = 2'b01; db_prio = 3'd4;
    step();
    chk("R5 higher priority blocks", 32'(db_status), 0);
    db_prio = 3'd3;
    step();
    chk("R5 equal priority sets", 32'(db_status), 32'h1);
    idle_inputs(); sw_wr = 1; sw_sel = 1; sw_wdata = 4'b0001;
    step();
    chk("R3 data clear", 32'(db_status), 0);

    // R6: value compare on load needs valid data, store does not
    idle_inputs(); db_done = 1; db_match = 2'b10; db_valcmp = 2'b10;
    step();
    chk("R6 invalid load data ignored", 32'(db_status), 0);
    db_store = 1;
    step();
    chk("R6 store sets regardless", 32'(db_status), 32'h2);

    // R10: instruction over data, lowest index first
    idle_inputs(); ib_trig = '0; db_trig = '0;
    ib_match = 4'b1010; ib_retire = 1; db_done = 1; db_match = 2'b01;
    step();
    chk("R10 request raised", 32'(req), 1);
    chk("R10 instruction wins", 32'(req_data), 0);
    chk("R10 lowest channel", 32'(req_chan), 1);
    idle_inputs();
    step();
    chk("R8 pulse ends", 32'(req), 0);
    chk("R8 mode entered", 32'(mode), 1);

    // R9 and R7: imprecise match inside debug mode
    db_done = 1; db_match = 2'b10; db_imp = 1;
    step();
    chk("R9 no request in debug mode", 32'(req), 0);
    chk("R7 imprecise load flag set", 32'(imp_load), 1);
    idle_inputs(); dbg_ret = 1;
    step();
    chk("R8 mode left on return", 32'(mode), 0);
    idle_inputs();
    step();

    // Constrained random phase
    for (int n = 0; n < 3000; n++) begin
      ib_match  = NI'($urandom) & NI'($urandom) & NI'($urandom);
      ib_retire = ($urandom % 2) == 0;
      ib_exc    = ($urandom % 10) == 0;
      db_done   = ($urandom % 5) < 2;
      db_match  = ND'($urandom) & ND'($urandom);
      db_valcmp = ND'($urandom);
      db_store  = ($urandom % 2) == 0;
      db_imp    = ($urandom % 5) < 2;
      db_ok     = ($urandom % 10) < 7;
      db_prio   = 3'($urandom);
      dbg_ret   = ($urandom % 4) == 0;
      sw_wr     = ($urandom % 8) == 0;
      sw_sel    = ($urandom % 2) == 0;
      sw_wdata  = SWW'($urandom);
      if (($urandom % 16) == 0) begin
        ib_trig = NI'($urandom) & NI'($urandom);
        db_trig = ND'($urandom) & ND'($urandom);
      end
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule